// File: doc/BRIEF.md
# Escaped IPMI Frame Decoder

The decoder sits on the receive side of a byte-serial link that carries IPMI traffic between a virtual machine and a management controller. The link reserves three byte values. 0xA0 ends a message, 0xA1 ends a command and 0xAA escapes the next byte. Any payload byte that equals a reserved value is sent as 0xAA followed by that value with bit 4 set.

The decoder removes the escapes and writes each payload byte into an external 64-entry receive buffer. It keeps a running 8-bit sum as bytes arrive, so the sum is ready when a terminator arrives. A message terminator runs these checks in order: framing, then minimum length, then checksum. A message that passes has its checksum byte dropped from the delivered length, and buffer entries 0 and 1 are swapped so that the header has the order the BT side expects. Host-to-controller attention then rises and the decoder holds until the consumer pulses release. A command terminator reports the command and clears the receive state at once.

Top module: `vm_frame_decoder`

## Requirements
- R1: After reset every output is low or zero: write strobe, address, data, length, all three pulses, status and attention.
- R2: A byte accepted while no escape is pending and no overflow has occurred is written to the address equal to the number of bytes stored so far. The write strobe shows it in the cycle after acceptance. A byte that follows 0xAA is written with bit 4 cleared.
- R3: A byte is accepted only when enable and valid are both high. No byte is accepted after a message terminator until release, so the write strobe stays low in that interval.
- R4: Once 64 bytes are stored, any further ordinary byte is dropped and sets a sticky overflow, and 0xAA no longer arms an escape. A later terminator then raises the frame-error pulse and clears the receive state, so the next byte goes to address 0.
- R5: A terminator that arrives while an escape is pending raises the frame-error pulse, delivers nothing, leaves attention low and clears the receive state.
- R6: A terminator that arrives while no byte is stored has no visible effect: no pulse and no attention.
- R7: A message terminator that follows 1 to 3 stored bytes raises attention. One cycle later it raises message-done with status 1 (short) and a length equal to the byte count.
- R8: A message of 4 or more bytes whose 8-bit byte sum is not zero gives message-done with status 2 (bad checksum), the raw byte count as length, and attention, one cycle after the terminator.
- R9: A valid message writes original byte 1 to address 0 one cycle after the terminator, and original byte 0 to address 1 one cycle after that. One further cycle later it pulses message-done with status 0 and a length equal to the byte count minus one. Attention is set from the first of these cycles on.
- R10: A command terminator that follows stored bytes pulses command-done for one cycle, one cycle after the terminator, with the byte count as length and attention left low. The receive state is cleared, so the next byte goes to address 0.
- R11: A release pulse clears attention, the length output and all receive state, and input is accepted again starting at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Input enable; bytes are ignored while low |
| rx_valid | input | 1 | A byte is offered this cycle |
| rx_byte | input | 8 | Incoming link byte |
| rel_i | input | 1 | Release pulse from the consumer; clears all receive state |
| wr_en | output | 1 | Receive-buffer write strobe |
| wr_addr | output | 6 | Receive-buffer write address |
| wr_data | output | 8 | Receive-buffer write data |
| frame_len | output | 7 | Length of the last delivered message or command |
| msg_done | output | 1 | One-cycle pulse: a message terminator was judged |
| msg_status | output | 2 | 0 valid, 1 short, 2 bad checksum; meaningful with msg_done |
| cmd_done | output | 1 | One-cycle pulse: a command is delivered |
| frame_err | output | 1 | One-cycle pulse: a terminator arrived with an escape pending or after overflow |
| h2b_attn | output | 1 | Host-to-controller attention, held until release |

## Verification
A stored byte shows on the write port one cycle after the clock edge that accepts it. The error pulses, short and bad-checksum results and command-done also appear one cycle after the terminator edge. A valid message spreads its result over three cycles: the swap write of byte 1, then the swap write of byte 0, then message-done. The bench drives each byte on a falling edge and takes samples on later falling edges, counting one cycle per register on the path. That way each pulse is seen in its own cycle and is also seen to be gone in the next. The rest of the buffer contents are read from a mirror that the bench fills from the write port, and only once the write traffic has settled.

// File: rtl/vmf_pkg.sv
`timescale 1ns/1ps
package vmf_pkg;
   localparam logic [7:0] CH_MSG_END = 8'hA0;
   localparam logic [7:0] CH_CMD_END = 8'hA1;
   localparam logic [7:0] CH_ESC     = 8'hAA;

   typedef enum logic [1:0] {K_DATA, K_ESC, K_MSG_END, K_CMD_END} kind_e;
   typedef enum logic [1:0] {PH_RX, PH_SWAP1, PH_FIN, PH_HOLD} phase_e;

   localparam logic [1:0] ST_OK     = 2'd0;
   localparam logic [1:0] ST_SHORT  = 2'd1;
   localparam logic [1:0] ST_BADSUM = 2'd2;
endpackage

// File: rtl/vmf_classify.sv
`timescale 1ns/1ps
module vmf_classify
   import vmf_pkg::*;
(
   input  logic [7:0] byte_i,
   output kind_e      kind_o
);
   always_comb begin
      unique case (byte_i)
         CH_MSG_END: kind_o = K_MSG_END;
         CH_CMD_END: kind_o = K_CMD_END;
         CH_ESC:     kind_o = K_ESC;
         default:    kind_o = K_DATA;
      endcase
   end
endmodule

// File: rtl/vmf_accum.sv
`timescale 1ns/1ps
module vmf_accum #(
   parameter int DEPTH   = 64,
   parameter int ESC_BIT = 4,
   localparam int LEN_W  = $clog2(DEPTH) + 1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              trim_i,
   input  logic              take_i,
   input  logic              esc_i,
   input  logic [7:0]        data_i,
   output logic [LEN_W-1:0]  len_o,
   output logic [7:0]        sum_o,
   output logic              esc_o,
   output logic              ovf_o,
   output logic [7:0]        head0_o,
   output logic [7:0]        head1_o,
   output logic              store_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [7:0]        wdata_o
);
   localparam logic [7:0] ESC_MASK = 8'(1) << ESC_BIT;

   logic [LEN_W-1:0] len_q;
   logic [7:0]       sum_q, h0_q, h1_q;
   logic             esc_q, ovf_q;
   logic             full;
   logic [7:0]       plain;

   assign full    = (len_q == LEN_W'(DEPTH));
   assign plain   = esc_q ? (data_i & ~ESC_MASK) : data_i;
   assign store_o = take_i && !ovf_q && !full;
   assign addr_o  = len_q[ADDR_W-1:0];
   assign wdata_o = plain;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         len_q <= '0;
         sum_q <= '0;
         h0_q  <= '0;
         h1_q  <= '0;
         esc_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (trim_i) len_q <= len_q - LEN_W'(1);
         if (take_i) begin
            esc_q <= 1'b0;
            if (!ovf_q) begin
               if (full) begin
                  ovf_q <= 1'b1;
               end else begin
                  len_q <= len_q + LEN_W'(1);
                  sum_q <= sum_q + plain;
                  if (len_q == LEN_W'(0)) h0_q <= plain;
                  if (len_q == LEN_W'(1)) h1_q <= plain;
               end
            end
         end else if (esc_i && !ovf_q) begin
            esc_q <= 1'b1;
         end
      end
   end

   assign len_o   = len_q;
   assign sum_o   = sum_q;
   assign esc_o   = esc_q;
   assign ovf_o   = ovf_q;
   assign head0_o = h0_q;
   assign head1_o = h1_q;

   // R4: the count never passes the buffer depth
   a_r4_len_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= LEN_W'(DEPTH));
   // R4: overflow stays set until the frame is cleared
   a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_i) |=> ovf_q);
   // R4: no escape arms while overflowed
   a_r4_no_esc_in_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !esc_q && !clr_i) |=> !esc_q);
endmodule

// File: rtl/vm_frame_decoder.sv
`timescale 1ns/1ps
module vm_frame_decoder
   import vmf_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int MIN_MSG = 4,
   parameter int ESC_BIT = 4,
   localparam int LEN_W  = $clog2(DEPTH) + 1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              rel_i,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic [LEN_W-1:0]  frame_len,
   output logic              msg_done,
   output logic [1:0]        msg_status,
   output logic              cmd_done,
   output logic              frame_err,
   output logic              h2b_attn
);
   generate
      if (DEPTH < MIN_MSG || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two no smaller than MIN_MSG");
      end
      if (MIN_MSG < 2) begin : g_bad_min
         $error("MIN_MSG must cover the two swapped header bytes");
      end
      if (ESC_BIT < 0 || ESC_BIT > 7) begin : g_bad_esc
         $error("ESC_BIT must select a bit of a byte");
      end
   endgenerate

   kind_e             kind;
   phase_e            phase_q;
   logic [LEN_W-1:0]  len;
   logic [7:0]        sum, head0, head1, sdata;
   logic              esc, ovf, store;
   logic [ADDR_W-1:0] saddr;

   logic fire, term, bad_frame, msg_path, msg_valid, cmd_go, acc_clr;

   vmf_classify u_cls (.byte_i(rx_byte), .kind_o(kind));

   assign fire      = rx_en && rx_valid && (phase_q == PH_RX);
   assign term      = fire && (kind == K_MSG_END || kind == K_CMD_END);
   assign bad_frame = term && (esc || ovf);
   assign msg_path  = fire && (kind == K_MSG_END) && !esc && !ovf && (len != '0);
   assign msg_valid = msg_path && (len >= LEN_W'(MIN_MSG)) && (sum == 8'h00);
   assign cmd_go    = fire && (kind == K_CMD_END) && !esc && !ovf && (len != '0);
   assign acc_clr   = rel_i || bad_frame || cmd_go;

   vmf_accum #(.DEPTH(DEPTH), .ESC_BIT(ESC_BIT)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (acc_clr),
      .trim_i  (msg_valid),
      .take_i  (fire && kind == K_DATA),
      .esc_i   (fire && kind == K_ESC),
      .data_i  (rx_byte),
      .len_o   (len),
      .sum_o   (sum),
      .esc_o   (esc),
      .ovf_o   (ovf),
      .head0_o (head0),
      .head1_o (head1),
      .store_o (store),
      .addr_o  (saddr),
      .wdata_o (sdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q    <= PH_RX;
         wr_en      <= 1'b0;
         wr_addr    <= '0;
         wr_data    <= '0;
         frame_len  <= '0;
         msg_done   <= 1'b0;
         msg_status <= ST_OK;
         cmd_done   <= 1'b0;
         frame_err  <= 1'b0;
         h2b_attn   <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         msg_done  <= 1'b0;
         cmd_done  <= 1'b0;
         frame_err <= 1'b0;
         if (rel_i) begin
            phase_q   <= PH_RX;
            h2b_attn  <= 1'b0;
            frame_len <= '0;
         end else begin
            unique case (phase_q)
               PH_RX: begin
                  if (store) begin
                     wr_en   <= 1'b1;
                     wr_addr <= saddr;
                     wr_data <= sdata;
                  end
                  if (bad_frame) frame_err <= 1'b1;
                  if (cmd_go) begin
                     cmd_done  <= 1'b1;
                     frame_len <= len;
                  end
                  if (msg_path) begin
                     h2b_attn <= 1'b1;
                     if (msg_valid) begin
                        wr_en     <= 1'b1;
                        wr_addr   <= '0;
                        wr_data   <= head1;
                        frame_len <= len - LEN_W'(1);
                        phase_q   <= PH_SWAP1;
                     end else begin
                        msg_done   <= 1'b1;
                        msg_status <= (len < LEN_W'(MIN_MSG)) ? ST_SHORT : ST_BADSUM;
                        frame_len  <= len;
                        phase_q    <= PH_HOLD;
                     end
                  end
               end
               PH_SWAP1: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ADDR_W'(1);
                  wr_data <= head0;
                  phase_q <= PH_FIN;
               end
               PH_FIN: begin
                  msg_done   <= 1'b1;
                  msg_status <= ST_OK;
                  phase_q    <= PH_HOLD;
               end
               default: ;
            endcase
         end
      end
   end

   // R5: a frame error never coincides with a delivery
   a_r5_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> (!msg_done && !cmd_done));
   // R3: nothing is written while holding a message
   a_r3_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_HOLD) |=> !wr_en);
   // R4: an overflowed frame writes nothing
   a_r4_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && phase_q == PH_RX) |=> !wr_en);
   // R9: a judged message always comes with attention
   a_r9_done_attn: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done |-> h2b_attn);
   // R9: second swap write targets address 1
   a_r9_swap_order: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SWAP1 && !rel_i) |=> (wr_en && wr_addr == ADDR_W'(1)));
   // R10: commands never raise attention
   a_r10_cmd_no_attn: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> !h2b_attn);
   // R11: release drops attention on the next cycle
   a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
      rel_i |=> (!h2b_attn && !msg_done && !cmd_done));
endmodule

// File: tb/vm_frame_decoder_test.sv
`timescale 1ns/1ps
module vm_frame_decoder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_en = 1'b1;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       rel_i = 1'b0;
   logic       wr_en;
   logic [5:0] wr_addr;
   logic [7:0] wr_data;
   logic [6:0] frame_len;
   logic       msg_done, cmd_done, frame_err, h2b_attn;
   logic [1:0] msg_status;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   int wr_count = 0;
   logic [7:0] shadow [0:63];
   logic [7:0] m [0:15];

   always #2 clk = ~clk;

   vm_frame_decoder uut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .rel_i(rel_i), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .frame_len(frame_len), .msg_done(msg_done),
      .msg_status(msg_status), .cmd_done(cmd_done), .frame_err(frame_err),
      .h2b_attn(h2b_attn)
   );

   always @(negedge clk) begin
      if (wr_en) begin
         shadow[wr_addr] <= wr_data;
         wr_count <= wr_count + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      if (b == 8'hA0 || b == 8'hA1 || b == 8'hAA) begin
         put(8'hAA);
         put(b | 8'h10);
      end else begin
         put(b);
      end
   endtask

   task automatic release_rx();
      @(negedge clk);
      rel_i = 1'b1;
      @(negedge clk);
      rel_i = 1'b0;
   endtask

   function automatic logic [7:0] pick();
      int r = $urandom % 8;
      case (r)
         0: return 8'hA0;
         1: return 8'hA1;
         2: return 8'hAA;
         default: return 8'($urandom);
      endcase
   endfunction

   task automatic run_valid(input int n);
      logic [7:0] s = 8'h00;
      int c;
      int ok;
      for (int i = 0; i < n - 1; i++) begin
         m[i] = pick();
         s = s + m[i];
      end
      m[n-1] = 8'h00 - s;
      for (int i = 0; i < n; i++) send(m[i]);
      put(8'hA0);
      chk("R9 swap0 strobe", int'(wr_en), 1);
      chk("R9 swap0 addr", int'(wr_addr), 0);
      chk("R9 swap0 data", int'(wr_data), int'(m[1]));
      chk("R9 attn", int'(h2b_attn), 1);
      chk("R9 done early", int'(msg_done), 0);
      tick();
      chk("R9 swap1 addr", int'(wr_addr), 1);
      chk("R9 swap1 data", int'(wr_data), int'(m[0]));
      tick();
      chk("R9 done", int'(msg_done), 1);
      chk("R9 status", int'(msg_status), 0);
      chk("R9 len", int'(frame_len), n - 1);
      tick(); tick();
      chk("R9 done pulse", int'(msg_done), 0);
      ok = 1;
      for (int k = 2; k < n; k++) if (shadow[k] !== m[k]) ok = 0;
      chk("R2 stored bytes", ok, 1);
      c = wr_count;
      put(8'h11);
      tick();
      chk("R3 hold ignores input", wr_count, c);
      release_rx();
      chk("R11 attn cleared", int'(h2b_attn), 0);
      chk("R11 len cleared", int'(frame_len), 0);
   endtask

   initial begin
      int c;
      void'($urandom(32'h5eed1234));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 outputs idle", int'({wr_en, wr_addr, wr_data, frame_len, msg_done,
          msg_status, cmd_done, frame_err, h2b_attn}), 0);

      // R3 enable low
      rx_en = 1'b0;
      put(8'h09);
      tick();
      chk("R3 enable low", wr_count, 0);
      rx_en = 1'b1;

      // R2 unescape
      put(8'hAA);
      put(8'h35);
      chk("R2 strobe", int'(wr_en), 1);
      chk("R2 addr", int'(wr_addr), 0);
      chk("R2 unescaped", int'(wr_data), 8'h25);
      release_rx();

      for (int it = 0; it < 20; it++) run_valid(4 + ($urandom % 11));

      // R6 empty terminators
      put(8'hA0);
      chk("R6 msg none", int'({msg_done, frame_err, h2b_attn}), 0);
      put(8'hA1);
      chk("R6 cmd none", int'({cmd_done, frame_err}), 0);

      // R7 short
      put(8'h01); put(8'h02); put(8'h03); put(8'hA0);
      chk("R7 done", int'(msg_done), 1);
      chk("R7 status", int'(msg_status), 1);
      chk("R7 len", int'(frame_len), 3);
      chk("R7 attn", int'(h2b_attn), 1);
      release_rx();

      // R8 bad checksum
      put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'hA0);
      chk("R8 done", int'(msg_done), 1);
      chk("R8 status", int'(msg_status), 2);
      chk("R8 len", int'(frame_len), 4);
      release_rx();

      // R10 command
      put(8'hAA); put(8'hEF); put(8'h01); put(8'hA1);
      chk("R10 done", int'(cmd_done), 1);
      chk("R10 len", int'(frame_len), 2);
      chk("R10 no attn", int'({h2b_attn, msg_done}), 0);
      tick();
      chk("R10 pulse", int'(cmd_done), 0);
      put(8'h55);
      chk("R10 cleared", int'(wr_addr), 0);

      // R5 escape pending at terminator
      put(8'h05); put(8'hAA); put(8'hA0);
      chk("R5 err", int'(frame_err), 1);
      chk("R5 no msg", int'({msg_done, h2b_attn}), 0);
      put(8'h66);
      chk("R5 cleared", int'({wr_en, wr_addr}), 64);
      release_rx();

      // R4 overflow
      for (int i = 0; i < 64; i++) put(8'(i));
      put(8'h40);
      chk("R4 dropped", int'(wr_en), 0);
      c = wr_count;
      put(8'hAA); put(8'h35);
      tick();
      chk("R4 no escape", wr_count, c);
      put(8'hA0);
      chk("R4 err", int'(frame_err), 1);
      chk("R4 no msg", int'({msg_done, h2b_attn}), 0);
      put(8'h12);
      chk("R4 cleared", int'({wr_en, wr_addr}), 64);

      // R11 release mid-frame
      put(8'h22);
      release_rx();
      put(8'h07);
      chk("R11 restart", int'({wr_en, wr_addr}), 64);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule